// File: doc/BRIEF.md
# Tracking Ramp Generator with Fault Window

This block produces one shared digital reference ramp that every sequenced supply output must follow while it is being brought up or taken down in a controlled way. A sequencer raises `run_i` and picks the direction with `dir_up_i`. The ramp then moves by one code every `step_intv_i` clock cycles, with the same interval in both directions. The block takes each channel's digitized output voltage from an ADC and compares it with the ramp. A channel that trails the ramp by more than the stop window pauses the ramp until it catches up. A channel that strays more than twice the stop window from the ramp in either direction raises a tracking fault. The ramp is then abandoned, and the surrounding logic performs a fast shutdown.

The ADC inputs are a valid-only stream with no back-pressure. The block has no ready signal and accepts a code in every cycle in which its valid bit is high. Each channel keeps its last accepted code, and that held code is what the comparisons use. Run, direction, interval and mask are plain level controls. The ramp value, the fault flag and the done flag are plain outputs.

Top module: `track_ramp_gen`

## Requirements
- R1: After reset, `ramp_o` is 0, `fault_o` is 0 and `done_o` is 0.
- R2: While `run_i` is high and nothing stalls or faults, `ramp_o` moves by exactly one code every max(`step_intv_i`,1) cycles: up when `dir_up_i`=1, down when `dir_up_i`=0. The interval timer restarts when `run_i` rises. While `run_i` is low, `ramp_o` holds its value.
- R3: When `dir_up_i`=1, the ramp does not increment while any active held code satisfies code + STOP_WIN < ramp (lagging low).
- R4: When `dir_up_i`=0, the ramp does not decrement while any active held code satisfies code > ramp + STOP_WIN (lagging high). A lagging-low channel never pauses the ramp on the way down, and a lagging-high channel never pauses it on the way up.
- R5: While `run_i` is high, if any active held code is more than 2*STOP_WIN above or below the ramp, then at the next clock edge `fault_o` rises and `ramp_o` becomes 0. This applies in both directions.
- R6: Once raised, `fault_o` stays high and `ramp_o` stays 0 until `run_i` is low. `fault_o` then clears at the next clock edge.
- R7: The ramp saturates at 2^CODE_W-1 going up and at 0 going down. `done_o` is high while `run_i` is high, `fault_o` is low and the ramp sits at the end value for the current direction.
- R8: A channel whose `ch_mask_i` bit is 0 takes part in neither the stall checks nor the fault check.
- R9: Channel i's code occupies bits [i*CODE_W +: CODE_W] of `adc_code_i`. The code is taken only in a cycle where `adc_valid_i[i]` is 1 and is used for comparison from the next cycle on. The held value is kept while valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Ramp enable; low clears a latched fault |
| dir_up_i | input | 1 | 1 = power-up ramp, 0 = power-down ramp |
| step_intv_i | input | INTV_W | Cycles per ramp step (0 treated as 1) |
| ch_mask_i | input | NCH | 1 = channel is active in the comparisons |
| adc_code_i | input | NCH*CODE_W | Packed per-channel ADC codes |
| adc_valid_i | input | NCH | Per-channel code valid strobe |
| ramp_o | output | CODE_W | Reference ramp value |
| fault_o | output | 1 | Latched tracking fault |
| done_o | output | 1 | Ramp has reached its end value |

## Verification
A wrong held code or a wrong ramp register appears on `ramp_o` within one step interval. It shows up as a missing or extra step, or as a ramp that freezes at the wrong code. A wrong comparator result shows up either as a stall at an offset other than STOP_WIN+1 from the lagging channel, or as a spurious or missing `fault_o` one edge after the excursion. A wrong fault latch shows at once as a nonzero ramp while `fault_o` is high, or as `fault_o` persisting after `run_i` falls. The bench compares ramp, fault and done with a behavioural model on every cycle, so any divergence is caught in the cycle it appears.

// File: rtl/trg_pkg.sv
`timescale 1ns/1ps
package trg_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef struct packed {
    logic lag_lo;   // code trails ramp from below beyond stop window
    logic lag_hi;   // code trails ramp from above beyond stop window
    logic out_win;  // code outside fault window either side
  } cmp_flags_t;
endpackage

// File: rtl/trg_sample_hold.sv
`timescale 1ns/1ps
module trg_sample_hold #(
  parameter int NCH    = 3,
  parameter int CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*CODE_W-1:0] code_i,
  input  logic [NCH-1:0]        valid_i,
  output logic [NCH*CODE_W-1:0] held_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CODE_W-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          hold_q <= '0;
      else if (valid_i[g]) hold_q <= code_i[g*CODE_W +: CODE_W];
    end
    assign held_o[g*CODE_W +: CODE_W] = hold_q;

    // R9: the held code only moves in a cycle after valid was high
    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(valid_i[g]) && $past(rst_n)) |-> (hold_q == $past(hold_q)));
  end
endmodule

// File: rtl/trg_window_cmp.sv
`timescale 1ns/1ps
module trg_window_cmp
  import trg_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int STOP_WIN = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] ramp_i,
  output cmp_flags_t        flags_o
);
  localparam int XW        = CODE_W + 2;
  localparam int FAULT_WIN = 2 * STOP_WIN;

  logic [XW-1:0] code_x, ramp_x, stop_x, fault_x;

  always_comb begin
    code_x  = XW'(code_i);
    ramp_x  = XW'(ramp_i);
    stop_x  = XW'(STOP_WIN);
    fault_x = XW'(FAULT_WIN);
    flags_o.lag_lo  = (code_x + stop_x) < ramp_x;
    flags_o.lag_hi  = code_x > (ramp_x + stop_x);
    flags_o.out_win = ((code_x + fault_x) < ramp_x) || (code_x > (ramp_x + fault_x));
  end
endmodule

// File: rtl/trg_step_timer.sv
`timescale 1ns/1ps
module trg_step_timer #(
  parameter int INTV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [INTV_W-1:0] intv_i,
  output logic              tick_o
);
  logic [INTV_W-1:0] cnt_q;
  logic [INTV_W-1:0] eff;

  always_comb begin
    eff    = (intv_i == '0) ? INTV_W'(1) : intv_i;
    tick_o = !clr_i && (cnt_q >= eff - INTV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + INTV_W'(1);
  end

  // R2: with a steady interval the counter never passes the step point
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(intv_i)) |-> (cnt_q < eff));
endmodule

// File: rtl/track_ramp_gen.sv
`timescale 1ns/1ps
module track_ramp_gen
  import trg_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int CODE_W   = 8,
  parameter int STOP_WIN = 8,
  parameter int INTV_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic                  dir_up_i,
  input  logic [INTV_W-1:0]     step_intv_i,
  input  logic [NCH-1:0]        ch_mask_i,
  input  logic [NCH*CODE_W-1:0] adc_code_i,
  input  logic [NCH-1:0]        adc_valid_i,
  output logic [CODE_W-1:0]     ramp_o,
  output logic                  fault_o,
  output logic                  done_o
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  logic [NCH*CODE_W-1:0] held;
  cmp_flags_t [NCH-1:0]  flags;
  logic [NCH-1:0]        lo_v, hi_v, out_v;
  logic                  stall_up, stall_dn, win_bad, stall, tick;
  logic [CODE_W-1:0]     ramp_q;
  logic                  fault_q;
  dir_e                  dir;

  trg_sample_hold #(.NCH(NCH), .CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .code_i(adc_code_i),
    .valid_i(adc_valid_i), .held_o(held)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    trg_window_cmp #(.CODE_W(CODE_W), .STOP_WIN(STOP_WIN)) u_cmp (
      .code_i(held[g*CODE_W +: CODE_W]), .ramp_i(ramp_q), .flags_o(flags[g])
    );
    assign lo_v[g]  = ch_mask_i[g] && flags[g].lag_lo;
    assign hi_v[g]  = ch_mask_i[g] && flags[g].lag_hi;
    assign out_v[g] = ch_mask_i[g] && flags[g].out_win;
  end

  trg_step_timer #(.INTV_W(INTV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(!run_i || fault_q),
    .intv_i(step_intv_i), .tick_o(tick)
  );

  always_comb begin
    dir      = dir_e'(dir_up_i);
    stall_up = |lo_v;
    stall_dn = |hi_v;
    win_bad  = run_i && (|out_v);
    stall    = (dir == DIR_UP) ? stall_up : stall_dn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramp_q  <= '0;
      fault_q <= 1'b0;
    end else if (!run_i) begin
      fault_q <= 1'b0;
    end else if (fault_q || win_bad) begin
      fault_q <= 1'b1;
      ramp_q  <= '0;
    end else if (tick && !stall) begin
      if (dir == DIR_UP && ramp_q != FULL)        ramp_q <= ramp_q + CODE_W'(1);
      else if (dir == DIR_DOWN && ramp_q != '0)   ramp_q <= ramp_q - CODE_W'(1);
    end
  end

  assign ramp_o  = ramp_q;
  assign fault_o = fault_q;
  assign done_o  = run_i && !fault_q &&
                   ((dir == DIR_UP) ? (ramp_q == FULL) : (ramp_q == '0));

  // R6: the ramp is parked at zero whenever a fault is latched
  p_fault_parks_ramp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (ramp_o == '0));

  // R2: outside a fault the ramp moves by at most one code per cycle
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_o && $past(rst_n)) |->
      ((ramp_q == $past(ramp_q)) ||
       ({1'b0, ramp_q} == {1'b0, $past(ramp_q)} + (CODE_W+1)'(1)) ||
       ({1'b0, ramp_q} + (CODE_W+1)'(1) == {1'b0, $past(ramp_q)})));

  // R3: a low-lagging channel holds the rising ramp
  p_hold_rising_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run_i && dir_up_i && stall_up)) |-> (ramp_q <= $past(ramp_q)));

  // R4: a high-lagging channel holds the falling ramp
  p_hold_falling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run_i && !dir_up_i && stall_dn && !win_bad && !fault_q))
      |-> (ramp_q >= $past(ramp_q)));

  // R5: an out-of-window excursion while running latches the fault
  p_window_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_bad |=> fault_o);
endmodule

// File: tb/track_ramp_gen_bench.sv
`timescale 1ns/1ps
module track_ramp_gen_bench;
  localparam int NCH = 3, W = 8, SW = 8, IW = 12, FULL = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic run, dir_up;
  logic [IW-1:0] intv;
  logic [NCH-1:0] mask, valid;
  logic [NCH*W-1:0] codes;
  logic [W-1:0] ramp;
  logic fault, done;

  track_ramp_gen #(.NCH(NCH), .CODE_W(W), .STOP_WIN(SW), .INTV_W(IW)) u_track_ramp_gen (
    .clk(clk), .rst_n(rst_n), .run_i(run), .dir_up_i(dir_up), .step_intv_i(intv),
    .ch_mask_i(mask), .adc_code_i(codes), .adc_valid_i(valid),
    .ramp_o(ramp), .fault_o(fault), .done_o(done)
  );

  int checks = 0, errors = 0;
  string phase = "R1";

  // behavioural reference
  int m_ramp, m_cnt, m_ie;
  bit m_fault, m_stall, m_fc, m_tick;
  int m_cap[NCH];
  bit follow[NCH];
  int off[NCH];
  int fix[NCH];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ramp = 0; m_cnt = 0; m_fault = 0;
      for (int i = 0; i < NCH; i++) m_cap[i] = 0;
    end else begin
      m_stall = 0; m_fc = 0;
      for (int i = 0; i < NCH; i++) begin
        if (mask[i]) begin
          if (dir_up && m_cap[i] < m_ramp - SW) m_stall = 1;
          if (!dir_up && m_cap[i] > m_ramp + SW) m_stall = 1;
          if (m_cap[i] > m_ramp + 2*SW || m_cap[i] < m_ramp - 2*SW) m_fc = run;
        end
      end
      m_ie = (intv == 0) ? 1 : int'(intv);
      m_tick = run && !m_fault && (m_cnt >= m_ie - 1);
      if (!run) begin
        m_fault = 0; m_cnt = 0;
      end else if (m_fault || m_fc) begin
        m_fault = 1; m_ramp = 0; m_cnt = 0;
      end else if (m_tick) begin
        m_cnt = 0;
        if (!m_stall) begin
          if (dir_up && m_ramp < FULL) m_ramp++;
          else if (!dir_up && m_ramp > 0) m_ramp--;
        end
      end else m_cnt++;
      for (int i = 0; i < NCH; i++)
        if (valid[i]) m_cap[i] = int'(codes[i*W +: W]);
    end
  end

  // stimulus for ADC codes
  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NCH; i++) begin
      int v;
      v = follow[i] ? m_ramp + off[i] : fix[i];
      if (v < 0) v = 0;
      if (v > FULL) v = FULL;
      codes[i*W +: W] = W'(v);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " ramp"}, int'(ramp), m_ramp);
      chk({phase, " fault"}, int'(fault), int'(m_fault));
      chk({phase, " done"}, int'(done),
          int'(run && !m_fault && (dir_up ? (m_ramp == FULL) : (m_ramp == 0))));
    end
  end

  task automatic go(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int r;
  initial begin
    run = 0; dir_up = 1; intv = 3; mask = '1; valid = '1; codes = '0;
    for (int i = 0; i < NCH; i++) begin follow[i] = 1; off[i] = 0; fix[i] = 0; end
    go(3);
    chk("R1 reset ramp", int'(ramp), 0);
    chk("R1 reset fault", int'(fault), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1;
    go(2);

    // R2 up ramp, channel 2 leading high must not stall the rise (R4)
    phase = "R2"; off[2] = 12; run = 1;
    go(40);
    chk("R2 ramp advanced", int'(ramp > 0), 1);
    run = 0; r = int'(ramp);
    go(10);
    chk("R2 hold when idle", int'(ramp), r);
    off[2] = 0;

    // R3 channel 1 frozen: rise stops at r+STOP_WIN+1
    phase = "R3"; follow[1] = 0; fix[1] = r;
    go(3);
    run = 1;
    go(100);
    chk("R3 stall point", int'(ramp), r + SW + 1);

    // R8 masked channel no longer stalls
    phase = "R8"; mask = 3'b101;
    go(100);
    chk("R8 masked ignored", int'(ramp > r + SW + 1), 1);

    // R5/R6 unmasking far-off channel faults; fault sticks
    phase = "R5"; mask = '1;
    go(3);
    chk("R5 fault raised", int'(fault), 1);
    chk("R5 ramp cleared", int'(ramp), 0);
    phase = "R6";
    go(10);
    chk("R6 fault sticky", int'(fault), 1);
    run = 0;
    go(2);
    chk("R6 fault cleared", int'(fault), 0);

    // R7 full ramp up with interval 0
    phase = "R7"; follow[1] = 1; intv = 0;
    go(3);
    run = 1;
    go(300);
    chk("R7 top saturation", int'(ramp), FULL);
    chk("R7 done up", int'(done), 1);

    // R4 down: channel 2 stuck high stalls, channel 0 lagging low does not
    phase = "R4"; off[0] = -12; follow[2] = 0; fix[2] = FULL; dir_up = 0;
    go(100);
    chk("R4 stall point", int'(ramp), FULL - SW - 1);
    follow[2] = 1; off[0] = 0;
    phase = "R7";
    go(300);
    chk("R7 bottom saturation", int'(ramp), 0);
    chk("R7 done down", int'(done), 1);

    // R5 fault on low excursion while ramping down
    phase = "R5"; dir_up = 1;
    go(50);
    dir_up = 0;
    go(1);
    follow[0] = 0; fix[0] = m_ramp - 20;
    go(4);
    chk("R5 down fault", int'(fault), 1);
    run = 0; follow[0] = 1;
    go(3);

    // R9 codes with valid low are not taken
    phase = "R9"; dir_up = 1; run = 1;
    go(20);
    valid[0] = 0; follow[0] = 0; fix[0] = 250;
    go(20);
    chk("R9 invalid code ignored", int'(fault), 0);
    valid[0] = 1;
    go(4);
    chk("R9 valid code taken", int'(fault), 1);
    run = 0;
    go(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule